// File: doc/BRIEF.md
# Two-Delta Stride Pattern Prefetcher

This block sits beside a cache's miss path and watches one stream of demand requests, each carrying a cache-block address. It learns how the stream moves from one request to the next. The simplest case is an unchanging step. The block also learns a repeating rhythm made of two step sizes, where a short step occurs a fixed number of times and is then followed by one different step. An example is +1, +1, +5, +1, +1, +5. From what it has learned, the block predicts the next block of the stream and emits it as a prefetch request.

Every request that leaves the block, whether a demand or a prefetch, passes through a small table of outstanding requests. A block that is already in flight is never requested a second time. A completion input retires an entry once its data has arrived. Outputs are registered, so a demand presented in one cycle produces its forwarded request and its prefetch in the next cycle.

Top module: `delta_pattern_prefetcher`

## Requirements
- R1: While reset is held and on the first cycle after it, fwd_valid and pf_valid are low, no step pattern is held and the outstanding table is empty.
- R2: A demand whose block is not outstanding raises fwd_valid in the following cycle, with fwd_addr equal to the demand address.
- R3: When no pattern is held and the last three demand addresses differ by one equal step s, the block prefetches demand address + s, modulo 2^24.
- R4: When no pattern is held, a run of n equal steps d1 (n from 1 to 7, counting saturates at 7) followed by a different step d2 is stored as the pattern (d1 repeated n times, then d2). The confidence is set to 1 and no prefetch is issued for that demand.
- R5: Confidence is a 2-bit saturating counter. It rises by one when a step equals the step the pattern expects and falls by one otherwise. A held pattern issues prefetches only while the updated confidence is 2 or 3.
- R6: With a pattern held, the prefetch address is demand address + the next expected step. That step is d1 while fewer than n d1 steps have been taken since the last d2 step, and d2 otherwise. The position advances on every step, whether or not the step matched.
- R7: A mismatching step seen while the confidence is 1 or 0 drops the pattern. The block then returns to the behaviour of R3 and R4 and can learn again.
- R8: At most one prefetch is issued per demand. No prefetch is issued when the predicted address equals the demand address.
- R9: A demand to a block in the outstanding table is merged and not forwarded. A prefetch to such a block is suppressed.
- R10: The table holds 8 blocks, and a completion removes its block. When no slot is free, the prefetch is dropped and a new demand is still forwarded without being tracked.
- R11: A completion and a request to the same block in the same cycle apply the completion first, so the request counts as new.
- R12: In a cycle without a demand, no request is issued and the learned state is unchanged. Completions are still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dmd_valid | input | 1 | A demand request is present |
| dmd_addr | input | 24 | Cache-block address of the demand |
| done_valid | input | 1 | An outstanding request has completed |
| done_addr | input | 24 | Cache-block address of the completed request |
| fwd_valid | output | 1 | Demand forwarded to memory (registered) |
| fwd_addr | output | 24 | Address of the forwarded demand |
| pf_valid | output | 1 | Prefetch issued (registered) |
| pf_addr | output | 24 | Address of the prefetch |

## Verification
The delicate overlap is a completion that arrives in the same cycle as a demand for that same block. The completion must clear the entry before the lookup, so the demand is forwarded again and occupies a slot freed in that same cycle. The bench provokes this repeatedly. It completes the previous demand on every step of its stride sweeps, it sends a direct completion-plus-demand pair, and it issues repeated requests to a single address. Each result is judged against a queue-based model of the table and an arithmetic model of the step learner. The same sweeps also exercise the second overlap, in which one cycle inserts a demand and a prefetch into the table together near the full boundary.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

    localparam int DPP_ADDR_W = 24;
    localparam int DPP_RUN_W  = 3;
    localparam int DPP_CONF_W = 2;
    localparam int DPP_SLOTS  = 8;
    localparam int DPP_SLOT_W = $clog2(DPP_SLOTS);

    localparam logic [DPP_CONF_W-1:0] DPP_CONF_ON  = DPP_CONF_W'(2);
    localparam logic [DPP_CONF_W-1:0] DPP_CONF_MAX = {DPP_CONF_W{1'b1}};
    localparam logic [DPP_RUN_W-1:0]  DPP_RUN_MAX  = {DPP_RUN_W{1'b1}};

    typedef logic [DPP_ADDR_W-1:0] blk_addr_t;
    typedef logic [DPP_CONF_W-1:0] conf_t;
    typedef logic [DPP_RUN_W-1:0]  run_t;

    typedef struct packed {
        blk_addr_t last;
        logic      have_last;
        blk_addr_t prev_step;
        logic      have_prev;
        run_t      run;
        logic      learned;
        blk_addr_t d1;
        blk_addr_t d2;
        run_t      reps;
        run_t      pos;
        conf_t     conf;
    } learn_state_t;

    typedef struct packed {
        logic                  found;
        logic [DPP_SLOT_W-1:0] idx;
    } slot_pick_t;

    function automatic conf_t conf_up(conf_t c);
        return (c == DPP_CONF_MAX) ? c : c + conf_t'(1);
    endfunction

    function automatic conf_t conf_down(conf_t c);
        return (c == '0) ? c : c - conf_t'(1);
    endfunction

    function automatic run_t run_up(run_t r);
        return (r == DPP_RUN_MAX) ? r : r + run_t'(1);
    endfunction

    function automatic slot_pick_t pick_free(logic [DPP_SLOTS-1:0] busy);
        slot_pick_t r;
        r.found = 1'b0;
        r.idx   = '0;
        for (int i = DPP_SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                r.found = 1'b1;
                r.idx   = DPP_SLOT_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dpp_step_learner.sv
module dpp_step_learner
    import dpp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dmd_valid,
    input  blk_addr_t dmd_addr,
    output logic      cand_valid,
    output blk_addr_t cand_addr
);

    learn_state_t st, nxt;
    blk_addr_t    step;
    blk_addr_t    want_step;
    logic         step_repeat;

    assign step        = dmd_addr - st.last;
    assign want_step   = (st.pos < st.reps) ? st.d1 : st.d2;
    assign step_repeat = st.have_prev && (step == st.prev_step);

    always_comb begin
        nxt        = st;
        cand_valid = 1'b0;
        cand_addr  = dmd_addr;
        if (dmd_valid) begin
            if (st.have_last) begin
                if (st.learned) begin
                    // pattern mode: score the step, then step the position
                    if (step == want_step) begin
                        nxt.conf = conf_up(st.conf);
                    end else if (st.conf <= conf_t'(1)) begin
                        nxt.learned = 1'b0;
                        nxt.conf    = '0;
                    end else begin
                        nxt.conf = conf_down(st.conf);
                    end
                    if (nxt.learned) begin
                        nxt.pos    = (st.pos < st.reps) ? st.pos + run_t'(1) : '0;
                        cand_valid = (nxt.conf >= DPP_CONF_ON);
                        cand_addr  = dmd_addr + ((nxt.pos < st.reps) ? st.d1 : st.d2);
                    end
                end else if (st.have_prev) begin
                    if (step_repeat) begin
                        // plain mode: three addresses with one step
                        cand_valid = 1'b1;
                        cand_addr  = dmd_addr + step;
                    end else begin
                        nxt.learned = 1'b1;
                        nxt.d1      = st.prev_step;
                        nxt.reps    = st.run;
                        nxt.d2      = step;
                        nxt.pos     = '0;
                        nxt.conf    = conf_t'(1);
                    end
                end
                nxt.run       = step_repeat ? run_up(st.run) : run_t'(1);
                nxt.prev_step = step;
                nxt.have_prev = 1'b1;
            end
            nxt.last      = dmd_addr;
            nxt.have_last = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nxt;
        end
    end

endmodule

// File: rtl/dpp_req_filter.sv
module dpp_req_filter
    import dpp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dmd_valid,
    input  blk_addr_t dmd_addr,
    input  logic      cand_valid,
    input  blk_addr_t cand_addr,
    input  logic      done_valid,
    input  blk_addr_t done_addr,
    output logic      dmd_new,
    output logic      pf_go
);

    logic [DPP_SLOTS-1:0] busy_q;
    logic [DPP_SLOTS-1:0] busy_eff;
    logic [DPP_SLOTS-1:0] dmd_match;
    logic [DPP_SLOTS-1:0] cand_match;
    logic [DPP_SLOTS-1:0] first_mask;
    blk_addr_t            tag_q [DPP_SLOTS];

    slot_pick_t            pick_a, pick_b;
    logic                  dmd_ins;
    logic [DPP_SLOT_W-1:0] pf_slot;

    generate
        for (genvar i = 0; i < DPP_SLOTS; i++) begin : g_slot
            // a completion in this cycle frees the slot before lookup
            assign busy_eff[i]   = busy_q[i] & ~(done_valid & (tag_q[i] == done_addr));
            assign dmd_match[i]  = busy_eff[i] & (tag_q[i] == dmd_addr);
            assign cand_match[i] = busy_eff[i] & (tag_q[i] == cand_addr);
        end
    endgenerate

    assign pick_a     = pick_free(busy_eff);
    assign first_mask = (DPP_SLOTS'(1) << pick_a.idx) & {DPP_SLOTS{pick_a.found}};
    assign pick_b     = pick_free(busy_eff | first_mask);

    assign dmd_new = dmd_valid & ~|dmd_match;
    assign dmd_ins = dmd_new & pick_a.found;
    assign pf_go   = cand_valid & ~|cand_match & (cand_addr != dmd_addr)
                   & (dmd_ins ? pick_b.found : pick_a.found);
    assign pf_slot = dmd_ins ? pick_b.idx : pick_a.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else begin
            busy_q <= busy_eff;
            if (dmd_ins) begin
                busy_q[pick_a.idx] <= 1'b1;
                tag_q[pick_a.idx]  <= dmd_addr;
            end
            if (pf_go) begin
                busy_q[pf_slot] <= 1'b1;
                tag_q[pf_slot]  <= cand_addr;
            end
        end
    end

endmodule

// File: rtl/delta_pattern_prefetcher.sv
module delta_pattern_prefetcher
    import dpp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dmd_valid,
    input  logic [DPP_ADDR_W-1:0] dmd_addr,
    input  logic                  done_valid,
    input  logic [DPP_ADDR_W-1:0] done_addr,
    output logic                  fwd_valid,
    output logic [DPP_ADDR_W-1:0] fwd_addr,
    output logic                  pf_valid,
    output logic [DPP_ADDR_W-1:0] pf_addr
);

    logic      cand_valid;
    blk_addr_t cand_addr;
    logic      dmd_new;
    logic      pf_go;

    dpp_step_learner u_learn (
        .clk        (clk),
        .rst        (rst),
        .dmd_valid  (dmd_valid),
        .dmd_addr   (dmd_addr),
        .cand_valid (cand_valid),
        .cand_addr  (cand_addr)
    );

    dpp_req_filter u_filter (
        .clk        (clk),
        .rst        (rst),
        .dmd_valid  (dmd_valid),
        .dmd_addr   (dmd_addr),
        .cand_valid (cand_valid),
        .cand_addr  (cand_addr),
        .done_valid (done_valid),
        .done_addr  (done_addr),
        .dmd_new    (dmd_new),
        .pf_go      (pf_go)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid <= 1'b0;
            fwd_addr  <= '0;
            pf_valid  <= 1'b0;
            pf_addr   <= '0;
        end else begin
            fwd_valid <= dmd_new;
            pf_valid  <= pf_go;
            if (dmd_new) fwd_addr <= dmd_addr;
            if (pf_go)   pf_addr  <= cand_addr;
        end
    end

endmodule

// File: rtl/dpp_checker.sv
module dpp_checker
    import dpp_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  dmd_valid,
    input logic [DPP_ADDR_W-1:0] dmd_addr,
    input logic                  done_valid,
    input logic [DPP_ADDR_W-1:0] done_addr,
    input logic                  fwd_valid,
    input logic [DPP_ADDR_W-1:0] fwd_addr,
    input logic                  pf_valid,
    input logic [DPP_ADDR_W-1:0] pf_addr
);

    p_fwd_addr_r2: assert property (@(posedge clk) disable iff (rst)
        dmd_valid |=> (!fwd_valid || fwd_addr == $past(dmd_addr)));

    p_pf_not_dmd_r8: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> (pf_addr != $past(dmd_addr)));

    p_merge_r9: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && dmd_valid && dmd_addr == pf_addr
         && !(done_valid && done_addr == pf_addr)) |=> !fwd_valid);

    p_done_first_r11: assert property (@(posedge clk) disable iff (rst)
        (dmd_valid && done_valid && done_addr == dmd_addr)
        |=> (fwd_valid && fwd_addr == $past(dmd_addr)));

    p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !dmd_valid |=> (!fwd_valid && !pf_valid));

endmodule

bind delta_pattern_prefetcher dpp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .dmd_valid  (dmd_valid),
    .dmd_addr   (dmd_addr),
    .done_valid (done_valid),
    .done_addr  (done_addr),
    .fwd_valid  (fwd_valid),
    .fwd_addr   (fwd_addr),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr)
);

// File: tb/delta_pattern_prefetcher_test.sv
module delta_pattern_prefetcher_test;
    import dpp_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        dmd_valid;
    logic [23:0] dmd_addr;
    logic        done_valid;
    logic [23:0] done_addr;
    logic        fwd_valid;
    logic [23:0] fwd_addr;
    logic        pf_valid;
    logic [23:0] pf_addr;

    always #5 clk = ~clk;

    delta_pattern_prefetcher uut (
        .clk(clk), .rst(rst),
        .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .done_valid(done_valid), .done_addr(done_addr),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
        .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    int checks = 0;
    int errors = 0;

    // arithmetic model of the learner
    logic [23:0] m_last, m_sp, m_d1, m_d2;
    bit          m_hl, m_hs, m_learn;
    int          m_rc, m_n, m_pos, m_conf;
    logic [23:0] q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; dmd_valid = 1'b0; dmd_addr = '0; done_valid = 1'b0; done_addr = '0;
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
        m_hl = 0; m_hs = 0; m_learn = 0; m_rc = 0; m_n = 0; m_pos = 0; m_conf = 0;
        m_last = '0; m_sp = '0; m_d1 = '0; m_d2 = '0;
        q.delete();
        @(posedge clk);
        #2;
        chk(fwd_valid == 1'b0, "R1", "fwd_valid after reset", {31'd0, fwd_valid}, 0);
        chk(pf_valid == 1'b0, "R1", "pf_valid after reset", {31'd0, pf_valid}, 0);
    endtask

    task automatic cyc(input bit dv, input logic [23:0] da,
                       input bit cv, input logic [23:0] ca, input string req);
        bit          e_c, e_fwd, e_pf, hit;
        logic [23:0] e_ca, s, want;
        e_c = 0; e_ca = '0;
        if (dv) begin
            if (m_hl) begin
                s = da - m_last;
                if (m_learn) begin
                    want = (m_pos < m_n) ? m_d1 : m_d2;
                    if (s == want) m_conf = (m_conf == 3) ? 3 : m_conf + 1;
                    else if (m_conf <= 1) begin m_learn = 0; m_conf = 0; end
                    else m_conf = m_conf - 1;
                    if (m_learn) begin
                        m_pos = (m_pos < m_n) ? m_pos + 1 : 0;
                        if (m_conf >= 2) begin
                            e_c = 1;
                            e_ca = da + ((m_pos < m_n) ? m_d1 : m_d2);
                        end
                    end
                end else if (m_hs) begin
                    if (s == m_sp) begin e_c = 1; e_ca = da + s; end
                    else begin
                        m_learn = 1; m_d1 = m_sp; m_n = m_rc; m_d2 = s; m_pos = 0; m_conf = 1;
                    end
                end
                if (m_hs && s == m_sp) m_rc = (m_rc == 7) ? 7 : m_rc + 1;
                else m_rc = 1;
                m_sp = s; m_hs = 1;
            end
            m_last = da; m_hl = 1;
        end
        if (cv) begin
            for (int i = q.size() - 1; i >= 0; i--) if (q[i] == ca) q.delete(i);
        end
        hit = 0;
        foreach (q[i]) if (q[i] == da) hit = 1;
        e_fwd = dv && !hit;
        if (e_fwd && q.size() < 8) q.push_back(da);
        e_pf = 0;
        if (e_c && e_ca != da) begin
            hit = 0;
            foreach (q[i]) if (q[i] == e_ca) hit = 1;
            if (!hit && q.size() < 8) begin e_pf = 1; q.push_back(e_ca); end
        end
        dmd_valid = dv; dmd_addr = da; done_valid = cv; done_addr = ca;
        @(posedge clk);
        #2;
        dmd_valid = 1'b0; done_valid = 1'b0;
        chk(fwd_valid == e_fwd, req, "fwd_valid", {31'd0, fwd_valid}, {31'd0, e_fwd});
        if (e_fwd) chk(fwd_addr == da, "R2", "fwd_addr", {8'd0, fwd_addr}, {8'd0, da});
        chk(pf_valid == e_pf, req, "pf_valid", {31'd0, pf_valid}, {31'd0, e_pf});
        if (e_pf) chk(pf_addr == e_ca, req, "pf_addr", {8'd0, pf_addr}, {8'd0, e_ca});
    endtask

    task automatic run_seq(input logic [23:0] a, input bit first, input logic [23:0] prev,
                           input string req);
        cyc(1'b1, a, !first, prev, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] steps [5];
        logic [23:0] a, prev;
        steps[0] = 24'h1; steps[1] = 24'h2; steps[2] = 24'h3;
        steps[3] = 24'hFFFFFF; steps[4] = 24'h10;

        do_reset();

        // R3: plain constant stride sweep, completing the previous demand (R11)
        foreach (steps[k]) begin
            do_reset();
            a = 24'h1000 + 24'(k * 24'h100);
            prev = '0;
            for (int i = 0; i < 8; i++) begin
                run_seq(a, i == 0, prev, "R3");
                if (i == 2) chk(pf_valid && pf_addr == a + steps[k], "R3", "third address prefetch",
                                {8'd0, pf_addr}, {8'd0, a + steps[k]});
                prev = a;
                a = a + steps[k];
            end
        end

        // R4 R5 R6: two-step pattern sweep
        for (int d1 = 1; d1 <= 3; d1++) begin
            for (int n = 1; n <= 3; n++) begin
                for (int v = 0; v < 2; v++) begin
                    logic [23:0] d2;
                    int          pos;
                    d2 = (v == 0) ? 24'(d1 + 4) : 24'hFFFFFD;
                    do_reset();
                    a = 24'h20000; prev = '0; pos = 0;
                    for (int i = 0; i < 4 * (n + 1) + 2; i++) begin
                        run_seq(a, i == 0, prev, "R6");
                        prev = a;
                        if (pos < n) begin a = a + 24'(d1); pos++; end
                        else begin a = a + d2; pos = 0; end
                    end
                end
            end
        end

        // hand-worked 1,1,5 pattern then break (R4 R5 R6 R7 R9)
        do_reset();
        run_seq(24'h400, 1, 0, "R3");
        run_seq(24'h401, 0, 24'h400, "R3");
        run_seq(24'h402, 0, 24'h401, "R3");
        run_seq(24'h407, 0, 24'h402, "R4");
        chk(pf_valid == 1'b0, "R4", "no prefetch on learning", {31'd0, pf_valid}, 0);
        run_seq(24'h408, 0, 24'h407, "R5");
        chk(pf_valid && pf_addr == 24'h409, "R5", "first confident prefetch", {8'd0, pf_addr}, 24'h409);
        run_seq(24'h409, 0, 24'h408, "R9");
        chk(fwd_valid == 1'b0, "R9", "prefetched block merged", {31'd0, fwd_valid}, 0);
        chk(pf_valid && pf_addr == 24'h40E, "R6", "jump prefetch", {8'd0, pf_addr}, 24'h40E);
        run_seq(24'h40E, 0, 24'h409, "R6");
        run_seq(24'h500, 0, 24'h40E, "R5");
        run_seq(24'h600, 0, 24'h500, "R7");
        run_seq(24'h700, 0, 24'h600, "R7");
        run_seq(24'h800, 0, 24'h700, "R7");
        chk(pf_valid && pf_addr == 24'h900, "R7", "plain mode after drop", {8'd0, pf_addr}, 24'h900);

        // R8: repeated address yields no prefetch
        do_reset();
        for (int i = 0; i < 4; i++) begin
            run_seq(24'h50, i == 0, 24'h50, "R8");
            chk(pf_valid == 1'b0, "R8", "self prefetch suppressed", {31'd0, pf_valid}, 0);
        end

        // R10: fill the table without completions
        do_reset();
        cyc(1, 24'h010, 0, 0, "R10"); cyc(1, 24'h050, 0, 0, "R10");
        cyc(1, 24'h020, 0, 0, "R10"); cyc(1, 24'h090, 0, 0, "R10");
        cyc(1, 24'h030, 0, 0, "R10"); cyc(1, 24'h070, 0, 0, "R10");
        cyc(1, 24'h005, 0, 0, "R10"); cyc(1, 24'h0A0, 0, 0, "R10");
        cyc(1, 24'h0C0, 0, 0, "R10");
        chk(fwd_valid == 1'b1, "R10", "untracked demand forwarded", {31'd0, fwd_valid}, 1);
        cyc(1, 24'h0C0, 0, 0, "R10");
        chk(fwd_valid == 1'b1, "R10", "untracked demand forwarded again", {31'd0, fwd_valid}, 1);
        cyc(1, 24'h010, 0, 0, "R9");
        // R12: idle cycle with a completion
        cyc(0, 24'h123, 1, 24'h050, "R12");
        chk(fwd_valid == 1'b0 && pf_valid == 1'b0, "R12", "idle outputs",
            {30'd0, fwd_valid, pf_valid}, 0);
        cyc(1, 24'h050, 0, 0, "R10");
        chk(fwd_valid == 1'b1, "R10", "completed block requested anew", {31'd0, fwd_valid}, 1);

        // R11: completion and demand to one block in one cycle
        do_reset();
        cyc(1, 24'h777, 0, 0, "R2");
        cyc(1, 24'h777, 1, 24'h777, "R11");
        chk(fwd_valid == 1'b1, "R11", "completion applied first", {31'd0, fwd_valid}, 1);
        cyc(1, 24'h777, 0, 0, "R9");
        chk(fwd_valid == 1'b0, "R9", "outstanding demand merged", {31'd0, fwd_valid}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule